// File: doc/BRIEF.md
# Per-Flow Credit-Gated Transmit Scheduler

This block sits between a segment selector and the outgoing link and decides, cycle by cycle, which flow may put its next segment on the wire. For every flow it holds a short first-in first-out queue of pending segment IDs and a byte-valued credit, such as a congestion window or receiver-granted tokens. A flow can be picked only when it has a queued segment and its credit covers one full segment. Among the flows that qualify, a rotating pointer picks one, and the block issues a single (flow, segment) pair per cycle.

Credit changes come from three places. Each issue debits one fixed segment size. An acknowledgement returns the acknowledged bytes. A congestion notice halves the credit, but never below one segment. A free-running counter fires a refill tick at a fixed period, and the tick adds a configurable increment to every flow, saturating at a configurable ceiling. All changes that land on one flow in the same cycle are folded into a single update, so the block takes a new event every cycle with no stall. The reset input is asynchronous and is released through a two-flop synchronizer.

Top module: `credit_tx_sched`

## Requirements
- R1: Two clock edges after reset is released, tx_valid is 0, every queue is empty (in_ready is 1 for every flow), and every flow holds INIT_CREDIT bytes of credit.
- R2: A flow is issued only when its queue is non-empty and its credit is at least SEG_BYTES. Each issue subtracts SEG_BYTES from that flow's credit.
- R3: At most one (tx_flow, tx_seg) pair is valid per cycle. Segments of one flow leave in arrival order. A segment accepted at clock edge P on a flow that already qualifies is presented after edge P+1.
- R4: An acknowledgement adds ack_bytes to the credit of ack_flow, saturating at cfg_credit_max. Partial acknowledgements accumulate.
- R5: A congestion notice sets the credit of cnp_flow to half its value, rounded down, but never below SEG_BYTES.
- R6: in_ready is 0 exactly when the queue of the flow on in_flow holds QUEUE_DEPTH entries. A push to a full queue is dropped and never issued. Other flows stay ready.
- R7: Flows that qualify are served in rotating order starting after the last flow served, so two flows that both stay eligible alternate on back-to-back cycles.
- R8: An issue, an acknowledgement and a push on the same flow in the same cycle all take effect: no credit change and no segment is lost.
- R9: Every TICK_PERIOD cycles, each flow's credit grows by cfg_refill_inc. A flow with zero credit and queued segments therefore issues once per TICK_PERIOD cycles when the increment equals SEG_BYTES.
- R10: A refill tick never raises a credit above cfg_credit_max.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_refill_inc | input | CREDIT_W | Bytes added to each flow per refill tick |
| cfg_credit_max | input | CREDIT_W | Ceiling for refill and acknowledgement additions |
| in_valid | input | 1 | New segment offered |
| in_flow | input | FLOW_W | Flow of the offered segment |
| in_seg | input | SEG_ID_W | Segment ID of the offered segment |
| in_ready | output | 1 | Queue of in_flow has room |
| ack_valid | input | 1 | Acknowledgement event |
| ack_flow | input | FLOW_W | Flow being acknowledged |
| ack_bytes | input | CREDIT_W | Bytes returned to that flow |
| cnp_valid | input | 1 | Congestion notice event |
| cnp_flow | input | FLOW_W | Flow being throttled |
| tx_valid | output | 1 | A segment is issued this cycle |
| tx_flow | output | FLOW_W | Flow of the issued segment |
| tx_seg | output | SEG_ID_W | ID of the issued segment |

## Verification
On every cycle, the assertions check that no more than one flow is granted, that a granted flow has both a queued segment and a credit covering it, that every grant turns into an issue on the next cycle (and no issue appears without a grant), that a congestion notice never leaves a credit below one segment, and that a refill never pushes a credit over the ceiling. The bench scenarios are the only place where the sequence-level behaviour shows: the exact number of segments a given credit buys, acknowledgement and halving arithmetic, first-in first-out order, dropped pushes to a full queue, alternation between two eligible flows, an acknowledgement merging with a same-cycle debit, and the spacing between refill-driven issues.

// File: rtl/credit_sched_pkg.sv
package credit_sched_pkg;

  // Credit-changing events that can land on one flow in a single cycle.
  typedef struct packed {
    logic tx;    // segment issued: debit one segment
    logic ack;   // acknowledgement: credit returned
    logic cnp;   // congestion notice: halve with floor
    logic tick;  // periodic refill
  } credit_evt_t;

endpackage

// File: rtl/seg_queue.sv
module seg_queue #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W:0]    wr_ptr_q, wr_ptr_d;
  logic [PTR_W:0]    rd_ptr_q, rd_ptr_d;
  logic              do_push, do_pop;

  assign empty = (wr_ptr_q == rd_ptr_q);
  assign full  = (wr_ptr_q[PTR_W] != rd_ptr_q[PTR_W]) &&
                 (wr_ptr_q[PTR_W-1:0] == rd_ptr_q[PTR_W-1:0]);
  assign head  = mem[rd_ptr_q[PTR_W-1:0]];

  always_comb begin
    do_push  = push && !full;
    do_pop   = pop && !empty;
    wr_ptr_d = wr_ptr_q + (do_push ? 1'b1 : 1'b0);
    rd_ptr_d = rd_ptr_q + (do_pop ? 1'b1 : 1'b0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_d;
      if (do_pop)  rd_ptr_q <= rd_ptr_d;
    end
  end

  // Storage carries no reset; the pointers qualify its contents.
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q[PTR_W-1:0]] <= push_data;
  end

endmodule

// File: rtl/credit_unit.sv
module credit_unit
  import credit_sched_pkg::*;
#(
  parameter int CREDIT_W    = 20,
  parameter int SEG_BYTES   = 1024,
  parameter int INIT_CREDIT = 2048
) (
  input  logic                clk,
  input  logic                rst_n,
  input  credit_evt_t         evt,
  input  logic [CREDIT_W-1:0] ack_bytes,
  input  logic [CREDIT_W-1:0] refill_inc,
  input  logic [CREDIT_W-1:0] credit_max,
  output logic [CREDIT_W-1:0] credit
);
  localparam logic [CREDIT_W-1:0] SEG_C  = CREDIT_W'(SEG_BYTES);
  localparam logic [CREDIT_W-1:0] INIT_C = CREDIT_W'(INIT_CREDIT);

  logic [CREDIT_W-1:0] credit_q, credit_d;
  logic [CREDIT_W-1:0] after_tx, after_ack, after_cnp, after_tick;
  logic                upd_en;

  // Add with one guard bit, then clamp to the ceiling.
  function automatic logic [CREDIT_W-1:0] add_cap(
    input logic [CREDIT_W-1:0] a,
    input logic [CREDIT_W-1:0] b,
    input logic [CREDIT_W-1:0] lim
  );
    logic [CREDIT_W:0] sum;
    sum = {1'b0, a} + {1'b0, b};
    if (sum > {1'b0, lim}) return lim;
    return sum[CREDIT_W-1:0];
  endfunction

  // All same-cycle events fold into one read-modify-write.
  always_comb begin
    after_tx   = evt.tx ? (credit_q - SEG_C) : credit_q;
    after_ack  = evt.ack ? add_cap(after_tx, ack_bytes, credit_max) : after_tx;
    after_cnp  = after_ack;
    if (evt.cnp) begin
      after_cnp = after_ack >> 1;
      if (after_cnp < SEG_C) after_cnp = SEG_C;
    end
    after_tick = evt.tick ? add_cap(after_cnp, refill_inc, credit_max) : after_cnp;
    credit_d   = after_tick;
    upd_en     = evt.tx | evt.ack | evt.cnp | evt.tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      credit_q <= INIT_C;
    else if (upd_en) credit_q <= credit_d;
  end

  assign credit = credit_q;

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  output logic [N-1:0]         grant,
  output logic [$clog2(N)-1:0] grant_idx,
  output logic                 grant_any
);
  localparam int IDX_W = $clog2(N);

  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [IDX_W-1:0] probe;

  // Search starts at the flow after the last one served (N is a power of two).
  always_comb begin
    grant     = '0;
    grant_any = 1'b0;
    probe     = '0;
    for (int k = 0; k < N; k++) begin
      probe = ptr_q + IDX_W'(k);
      if (!grant_any && req[probe]) begin
        grant[probe] = 1'b1;
        grant_any    = 1'b1;
      end
    end
  end

  always_comb begin
    grant_idx = '0;
    for (int k = 0; k < N; k++) begin
      if (grant[k]) grant_idx = IDX_W'(k);
    end
    ptr_d = grant_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr_q <= '0;
    else if (grant_any) ptr_q <= ptr_d;
  end

endmodule

// File: rtl/credit_tx_sched.sv
module credit_tx_sched
  import credit_sched_pkg::*;
#(
  parameter int NUM_FLOWS   = 4,
  parameter int SEG_ID_W    = 16,
  parameter int QUEUE_DEPTH = 4,
  parameter int CREDIT_W    = 20,
  parameter int SEG_BYTES   = 1024,
  parameter int INIT_CREDIT = 2048,
  parameter int TICK_PERIOD = 256,
  localparam int FLOW_W     = $clog2(NUM_FLOWS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CREDIT_W-1:0] cfg_refill_inc,
  input  logic [CREDIT_W-1:0] cfg_credit_max,
  input  logic                in_valid,
  input  logic [FLOW_W-1:0]   in_flow,
  input  logic [SEG_ID_W-1:0] in_seg,
  output logic                in_ready,
  input  logic                ack_valid,
  input  logic [FLOW_W-1:0]   ack_flow,
  input  logic [CREDIT_W-1:0] ack_bytes,
  input  logic                cnp_valid,
  input  logic [FLOW_W-1:0]   cnp_flow,
  output logic                tx_valid,
  output logic [FLOW_W-1:0]   tx_flow,
  output logic [SEG_ID_W-1:0] tx_seg
);
  localparam int TICK_W = (TICK_PERIOD > 1) ? $clog2(TICK_PERIOD) : 1;
  localparam logic [TICK_W-1:0]   TICK_LAST = TICK_W'(TICK_PERIOD - 1);
  localparam logic [CREDIT_W-1:0] SEG_C     = CREDIT_W'(SEG_BYTES);

  // Reset: asserted at once, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // Refill tick counter.
  logic [TICK_W-1:0] tick_cnt_q, tick_cnt_d;
  logic              tick;

  always_comb begin
    tick       = (tick_cnt_q == TICK_LAST);
    tick_cnt_d = tick ? '0 : tick_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) tick_cnt_q <= '0;
    else             tick_cnt_q <= tick_cnt_d;
  end

  // Per-flow state.
  logic [NUM_FLOWS-1:0]                q_empty, q_full, q_push, elig;
  logic [NUM_FLOWS-1:0][SEG_ID_W-1:0]  q_head;
  logic [NUM_FLOWS-1:0][CREDIT_W-1:0]  credit;
  logic [NUM_FLOWS-1:0]                grant;
  logic [FLOW_W-1:0]                   gnt_idx;
  logic                                grant_any;

  for (genvar f = 0; f < NUM_FLOWS; f++) begin : g_flow
    credit_evt_t evt;

    always_comb begin
      q_push[f] = in_valid && (in_flow == FLOW_W'(f));
      evt.tx    = grant[f];
      evt.ack   = ack_valid && (ack_flow == FLOW_W'(f));
      evt.cnp   = cnp_valid && (cnp_flow == FLOW_W'(f));
      evt.tick  = tick;
      elig[f]   = !q_empty[f] && (credit[f] >= SEG_C);
    end

    seg_queue #(
      .DEPTH  (QUEUE_DEPTH),
      .DATA_W (SEG_ID_W)
    ) u_queue (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .push      (q_push[f]),
      .push_data (in_seg),
      .pop       (grant[f]),
      .head      (q_head[f]),
      .empty     (q_empty[f]),
      .full      (q_full[f])
    );

    credit_unit #(
      .CREDIT_W    (CREDIT_W),
      .SEG_BYTES   (SEG_BYTES),
      .INIT_CREDIT (INIT_CREDIT)
    ) u_credit (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .evt        (evt),
      .ack_bytes  (ack_bytes),
      .refill_inc (cfg_refill_inc),
      .credit_max (cfg_credit_max),
      .credit     (credit[f])
    );
  end

  rr_pick #(
    .N (NUM_FLOWS)
  ) u_pick (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req       (elig),
    .grant     (grant),
    .grant_idx (gnt_idx),
    .grant_any (grant_any)
  );

  assign in_ready = !q_full[in_flow];

  // Registered issue port.
  logic                tx_valid_q;
  logic [FLOW_W-1:0]   tx_flow_q;
  logic [SEG_ID_W-1:0] tx_seg_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tx_valid_q <= 1'b0;
      tx_flow_q  <= '0;
      tx_seg_q   <= '0;
    end else begin
      tx_valid_q <= grant_any;
      if (grant_any) begin
        tx_flow_q <= gnt_idx;
        tx_seg_q  <= q_head[gnt_idx];
      end
    end
  end

  assign tx_valid = tx_valid_q;
  assign tx_flow  = tx_flow_q;
  assign tx_seg   = tx_seg_q;

endmodule

// File: rtl/credit_tx_sched_chk.sv
module credit_tx_sched_chk #(
  parameter int NUM_FLOWS = 4,
  parameter int CREDIT_W  = 20,
  parameter int SEG_BYTES = 1024,
  localparam int FLOW_W   = $clog2(NUM_FLOWS)
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [NUM_FLOWS-1:0]               grant,
  input logic [FLOW_W-1:0]                  gnt_idx,
  input logic [NUM_FLOWS-1:0]               q_empty,
  input logic [NUM_FLOWS-1:0][CREDIT_W-1:0] credit,
  input logic                               tick,
  input logic                               cnp_valid,
  input logic [FLOW_W-1:0]                  cnp_flow,
  input logic [CREDIT_W-1:0]                cfg_credit_max,
  input logic                               tx_valid,
  input logic [FLOW_W-1:0]                  tx_flow
);
  localparam logic [CREDIT_W-1:0] SEG_C = CREDIT_W'(SEG_BYTES);

  assert_single_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_grant_issues_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |=> (tx_valid && tx_flow == $past(gnt_idx)));

  assert_no_spurious_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(|grant) |=> !tx_valid);

  for (genvar f = 0; f < NUM_FLOWS; f++) begin : g_chk
    assert_grant_has_credit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      grant[f] |-> (credit[f] >= SEG_C));

    assert_grant_has_segment_R2: assert property (@(posedge clk) disable iff (!rst_n)
      grant[f] |-> !q_empty[f]);

    assert_cnp_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnp_valid && cnp_flow == FLOW_W'(f) && cfg_credit_max >= SEG_C)
        |=> (credit[f] >= SEG_C));

    assert_tick_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (credit[f] <= $past(cfg_credit_max)));
  end

endmodule

bind credit_tx_sched credit_tx_sched_chk #(
  .NUM_FLOWS (NUM_FLOWS),
  .CREDIT_W  (CREDIT_W),
  .SEG_BYTES (SEG_BYTES)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .grant          (grant),
  .gnt_idx        (gnt_idx),
  .q_empty        (q_empty),
  .credit         (credit),
  .tick           (tick),
  .cnp_valid      (cnp_valid),
  .cnp_flow       (cnp_flow),
  .cfg_credit_max (cfg_credit_max),
  .tx_valid       (tx_valid),
  .tx_flow        (tx_flow)
);

// File: tb/credit_tx_sched_tb.sv
module credit_tx_sched_tb;
  localparam int NF   = 4;
  localparam int SW   = 16;
  localparam int QD   = 4;
  localparam int CW   = 16;
  localparam int SEG  = 100;
  localparam int INIT = 200;
  localparam int TP   = 64;
  localparam int FW   = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cfg_refill_inc = '0;
  logic [CW-1:0] cfg_credit_max = CW'(1000);
  logic          in_valid = 1'b0;
  logic [FW-1:0] in_flow = '0;
  logic [SW-1:0] in_seg = '0;
  logic          in_ready;
  logic          ack_valid = 1'b0;
  logic [FW-1:0] ack_flow = '0;
  logic [CW-1:0] ack_bytes = '0;
  logic          cnp_valid = 1'b0;
  logic [FW-1:0] cnp_flow = '0;
  logic          tx_valid;
  logic [FW-1:0] tx_flow;
  logic [SW-1:0] tx_seg;

  credit_tx_sched #(
    .NUM_FLOWS (NF), .SEG_ID_W (SW), .QUEUE_DEPTH (QD), .CREDIT_W (CW),
    .SEG_BYTES (SEG), .INIT_CREDIT (INIT), .TICK_PERIOD (TP)
  ) u_dut (
    .clk (clk), .rst_n (rst_n),
    .cfg_refill_inc (cfg_refill_inc), .cfg_credit_max (cfg_credit_max),
    .in_valid (in_valid), .in_flow (in_flow), .in_seg (in_seg), .in_ready (in_ready),
    .ack_valid (ack_valid), .ack_flow (ack_flow), .ack_bytes (ack_bytes),
    .cnp_valid (cnp_valid), .cnp_flow (cnp_flow),
    .tx_valid (tx_valid), .tx_flow (tx_flow), .tx_seg (tx_seg)
  );

  always #4 clk = ~clk;  // 125 MHz

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int n_log = 0;
  int log_flow [256];
  int log_seg  [256];
  int log_cyc  [256];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && tx_valid && n_log < 256) begin
      log_flow[n_log] = int'(tx_flow);
      log_seg[n_log]  = int'(tx_seg);
      log_cyc[n_log]  = cyc;
      n_log++;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int count_flow(input int f);
    int c = 0;
    for (int i = 0; i < n_log; i++) if (log_flow[i] == f) c++;
    return c;
  endfunction

  function automatic int nth_seg(input int f, input int n);
    int c = 0;
    for (int i = 0; i < n_log; i++) begin
      if (log_flow[i] == f) begin
        if (c == n) return log_seg[i];
        c++;
      end
    end
    return -1;
  endfunction

  // All drive tasks start and end just after a rising edge.
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cfg_refill_inc = '0;
    cfg_credit_max = CW'(1000);
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    idle(3);
    n_log = 0;
  endtask

  task automatic push(input int f, input int s);
    in_valid = 1'b1; in_flow = FW'(f); in_seg = SW'(s);
    idle(1);
    in_valid = 1'b0;
  endtask

  task automatic ack(input int f, input int b);
    ack_valid = 1'b1; ack_flow = FW'(f); ack_bytes = CW'(b);
    idle(1);
    ack_valid = 1'b0;
  endtask

  task automatic cnp(input int f);
    cnp_valid = 1'b1; cnp_flow = FW'(f);
    idle(1);
    cnp_valid = 1'b0;
  endtask

  task automatic ready_of(input int f, output int r);
    in_flow = FW'(f);
    #1;
    r = int'(in_ready);
  endtask

  task automatic t_reset();
    int r;
    do_reset();
    check("R1", "tx_valid after reset", int'(tx_valid), 0);
    ready_of(0, r); check("R1", "in_ready flow0", r, 1);
    ready_of(3, r); check("R1", "in_ready flow3", r, 1);
  endtask

  task automatic t_gate_ack();
    int cp;
    do_reset();
    push(0, 10);
    cp = cyc;
    push(0, 11);
    push(0, 12);
    idle(5);
    check("R1", "segments bought by initial credit", count_flow(0), 2);
    check("R3", "first issue cycle", log_cyc[0], cp + 1);
    check("R3", "order first", nth_seg(0, 0), 10);
    check("R3", "order second", nth_seg(0, 1), 11);
    ack(0, 100);
    idle(4);
    check("R4", "issue after full ack", count_flow(0), 3);
    check("R4", "seg after ack", nth_seg(0, 2), 12);
    ack(0, 50);
    push(0, 13);
    idle(4);
    check("R2", "half segment credit blocks", count_flow(0), 3);
    ack(0, 50);
    idle(4);
    check("R4", "partial acks accumulate", count_flow(0), 4);
  endtask

  task automatic t_cnp();
    do_reset();
    cnp(1);
    push(1, 1); push(1, 2); push(1, 3);
    idle(5);
    check("R5", "halved to one segment", count_flow(1), 1);
    ack(2, 400);
    cnp(2);
    push(2, 1); push(2, 2); push(2, 3); push(2, 4);
    idle(8);
    check("R5", "600 halved to 300", count_flow(2), 3);
  endtask

  task automatic t_full();
    int r;
    do_reset();
    push(0, 1); push(0, 2);
    idle(4);
    check("R2", "credit spent", count_flow(0), 2);
    push(0, 3); push(0, 4); push(0, 5); push(0, 6);
    ready_of(0, r); check("R6", "full flow not ready", r, 0);
    ready_of(1, r); check("R6", "other flow ready", r, 1);
    push(0, 7);
    ack(0, 500);
    idle(10);
    check("R6", "queued segments issued", count_flow(0), 6);
    check("R6", "first queued", nth_seg(0, 2), 3);
    check("R6", "last queued", nth_seg(0, 5), 6);
    ready_of(0, r); check("R6", "ready after drain", r, 1);
    push(0, 8);
    idle(4);
    check("R6", "dropped push never issued", nth_seg(0, 6), 8);
  endtask

  task automatic t_rr();
    int n0;
    do_reset();
    push(0, 1); push(0, 2); push(1, 3); push(1, 4);
    idle(4);
    n0 = n_log;
    push(0, 10); push(0, 11); push(1, 20); push(1, 21);
    ack(0, 200);
    ack(1, 200);
    idle(8);
    check("R7", "issue count", n_log - n0, 4);
    check("R7", "slot0 flow", log_flow[n0],     0);
    check("R7", "slot1 flow", log_flow[n0 + 1], 1);
    check("R7", "slot2 flow", log_flow[n0 + 2], 0);
    check("R7", "slot3 flow", log_flow[n0 + 3], 1);
    check("R7", "slot1 seg",  log_seg[n0 + 1],  20);
    check("R7", "back to back", log_cyc[n0 + 3] - log_cyc[n0 + 1], 2);
  endtask

  task automatic t_merge();
    do_reset();
    push(0, 1);
    idle(3);
    in_valid = 1'b1; in_flow = 2'd0; in_seg = 16'd2;
    idle(1);
    in_seg = 16'd3;
    ack_valid = 1'b1; ack_flow = 2'd0; ack_bytes = CW'(100);
    idle(1);
    in_valid = 1'b0; ack_valid = 1'b0;
    idle(5);
    check("R8", "ack merged with debit", count_flow(0), 3);
    check("R8", "push merged with pop", nth_seg(0, 2), 3);
    push(0, 4);
    idle(5);
    check("R8", "debit not lost", count_flow(0), 3);
    ack(0, 100);
    idle(4);
    check("R8", "resume after ack", count_flow(0), 4);
  endtask

  task automatic t_tick_cap();
    do_reset();
    cfg_refill_inc = CW'(1000);
    cfg_credit_max = CW'(200);
    idle(2 * TP + 12);
    cfg_refill_inc = '0;
    cfg_credit_max = CW'(1000);
    push(3, 1); push(3, 2); push(3, 3); push(3, 4);
    idle(8);
    check("R10", "refill capped", count_flow(3), 2);
  endtask

  task automatic t_tick_rate();
    int n0;
    do_reset();
    push(2, 1); push(2, 2); push(2, 3); push(2, 4); push(2, 5);
    idle(4);
    n0 = n_log;
    check("R2", "issued before refill", n0, 2);
    cfg_refill_inc = CW'(SEG);
    idle(4 * TP + 10);
    check("R9", "refill issues", n_log - n0, 3);
    check("R9", "spacing 1", log_cyc[n0 + 1] - log_cyc[n0], TP);
    check("R9", "spacing 2", log_cyc[n0 + 2] - log_cyc[n0 + 1], TP);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_gate_ack();
    t_cnp();
    t_full();
    t_rr();
    t_merge();
    t_tick_cap();
    t_tick_rate();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule